// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration bitstream into an SRAM-based programmable logic device over a passive serial link. It is a hardware sequencer that replaces processor software toggling pins. A request on `start_i` latches the byte count and the restart policy. The block then runs three phases. In the reset phase, the active-low configuration request is driven low for a fixed pulse and the device's status line is expected to fall. In the data phase, the block waits for status to rise, waits a settle time, then shifts each byte out least-significant bit first on a divided serial clock. In the initialization phase, it sends a burst of extra clock pulses and then reads the done line.

Configuration bytes arrive on a valid/ready stream. `byte_ready_o` is high only while the block waits for the next byte, so a byte is never taken before the previous one has been shifted out. The device's status and done inputs pass through two-flop synchronizers before the sequencer uses them. The result of a load is held on `done_ok_o`, `err_o` and `err_code_o` until the next accepted start. The error codes are 1 for no response, 2 for timeout, 3 for a configuration error and 4 for done not seen.

The states are Idle, ResetLow, WaitStatus, Settle, Fetch, BitLow, BitHigh, Tail, InitLow, InitHigh, Final and Recover. The transitions are:
- Idle→ResetLow on start.
- ResetLow→WaitStatus, or ResetLow→Idle with no response.
- WaitStatus→Settle on status high, or WaitStatus→Idle on timeout.
- Settle→Fetch, or Settle→Tail when the count is zero.
- Fetch→BitLow on a handshake.
- BitLow→BitHigh, or BitLow→Recover/Idle when status drops.
- BitHigh→BitLow for the next bit, BitHigh→Fetch for the next byte, or BitHigh→Tail after the last byte.
- Tail→InitLow, or Tail→Idle when status is low.
- InitLow→InitHigh, InitHigh→InitLow, and InitHigh→Final after the last pulse.
- Final→Idle.
- Recover→Settle on a status rise, or Recover→Idle on timeout.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset the request output is high, the serial clock and data are low, and busy, ready, ok and error are all low.
- R2: A start taken in Idle drives the request output low for exactly PULSE_CYC clock cycles. The serial clock and data stay low whenever the request output is low.
- R3: If synchronized status is still high at the end of the request pulse, the load ends with code 1, and the request output stays low until the next start.
- R4: The first serial clock rise comes no sooner than DELAY_CYC cycles after status rises. Every high level of the serial clock lasts exactly DIV_CYC cycles.
- R5: Each byte is sent least-significant bit first, one bit per rising edge. Data is stable while the clock is high, and ready is never high while the clock is high.
- R6: If status reads low during the data phase, or at the check after the last byte, the load stops with code 3 and no further clock edges are sent.
- R7: After the last data bit, exactly INIT_CLKS more clock pulses are sent, with data held low.
- R8: The ok output is set only when the done input is high after the initialization pulses. Otherwise the load ends with code 4. Ok and error are never high together.
- R9: If status does not rise within TIMEOUT_CYC cycles after the request is released, the load ends with code 2.
- R10: With the restart policy set, a status drop during data sends one pulse on `restart_o`. After status rises again, the data phase restarts from byte 0 without a new request pulse.
- R11: A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (taken in Idle only) |
| auto_restart_i | input | 1 | Restart policy, latched at start |
| total_bytes_i | input | LEN_W | Byte count, latched at start |
| byte_data_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Block takes a byte |
| ncfg_o | output | 1 | Active-low configuration request |
| dclk_o | output | 1 | Serial clock |
| data0_o | output | 1 | Serial data |
| nstatus_i | input | 1 | Device status (asynchronous) |
| confdone_i | input | 1 | Device done (asynchronous) |
| busy_o | output | 1 | Load in progress |
| restart_o | output | 1 | Pulse: source must rewind to byte 0 |
| done_ok_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load failed |
| err_code_o | output | 3 | Cause of the last failure |

## Verification
A wrong state or timer value shows up at the pins within one serial clock half-period. A stuck shifter or bit index shows up as wrong bytes captured by the device model on the next rising edges. A wrong byte or pulse counter changes the total number of rising edges, which the bench counts against 8·N+INIT_CLKS. A wrong decision on status or done shows up as a wrong error code, or as extra or missing clock edges, when busy falls at the end of the load.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RST_LOW, S_WAIT_ST, S_SETTLE, S_FETCH, S_BIT_LO,
        S_BIT_HI, S_TAIL, S_INIT_LO, S_INIT_HI, S_FINAL, S_RECOVER
    } ps_state_e;

    localparam logic [2:0] E_NONE    = 3'd0;
    localparam logic [2:0] E_NORESP  = 3'd1;
    localparam logic [2:0] E_TIMEOUT = 3'd2;
    localparam logic [2:0] E_CFG     = 3'd3;
    localparam logic [2:0] E_NODONE  = 3'd4;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 2'b00;
            else        ff <= {ff[0], d_i[g]};
        end
        assign q_o[g] = ff[1];
    end
endmodule

// File: rtl/ps_shift.sv
module ps_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int IW = $clog2(BYTE_W);
    logic [BYTE_W-1:0] sr_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sr_q  <= data_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sr_q  <= sr_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sr_q[0];
    assign last_o = (idx_q == IW'(BYTE_W - 1));
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int DIV_CYC     = 4,
    parameter int PULSE_CYC   = 2000,
    parameter int DELAY_CYC   = 1250,
    parameter int TIMEOUT_CYC = 250000,
    parameter int INIT_CLKS   = 50,
    parameter int LEN_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             auto_restart_i,
    input  logic [LEN_W-1:0] total_bytes_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             ncfg_o,
    output logic             dclk_o,
    output logic             data0_o,
    input  logic             nstatus_i,
    input  logic             confdone_i,
    output logic             busy_o,
    output logic             restart_o,
    output logic             done_ok_o,
    output logic             err_o,
    output logic [2:0]       err_code_o
);
    localparam int MAXL   = imax(imax(DIV_CYC, PULSE_CYC), imax(DELAY_CYC, TIMEOUT_CYC));
    localparam int TMR_W  = $clog2(MAXL + 1);
    localparam int ICNT_W = $clog2(INIT_CLKS + 1);

    ps_state_e          state_q, state_d;
    logic [TMR_W-1:0]   tmr_q, lim;
    logic               tmr_hit;
    logic [LEN_W-1:0]   total_q, byte_cnt_q;
    logic [ICNT_W-1:0]  init_cnt_q;
    logic               auto_q, hold_low_q, ok_q, err_q, restart_q;
    logic [2:0]         code_q;
    logic               ns_s, cd_s, sh_bit, sh_last;
    logic               fin_err, fin_ok, do_restart;
    logic [2:0]         fin_code;
    logic               take_byte, shift_now;

    ps_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({confdone_i, nstatus_i}), .q_o({cd_s, ns_s})
    );

    assign take_byte = (state_q == S_FETCH) && byte_valid_i;
    assign shift_now = (state_q == S_BIT_HI) && tmr_hit;

    ps_shift #(.BYTE_W(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(take_byte), .data_i(byte_data_i),
        .shift_i(shift_now), .bit_o(sh_bit), .last_o(sh_last)
    );

    always_comb begin
        unique case (state_q)
            S_RST_LOW:            lim = TMR_W'(PULSE_CYC);
            S_WAIT_ST, S_RECOVER: lim = TMR_W'(TIMEOUT_CYC);
            S_SETTLE:             lim = TMR_W'(DELAY_CYC);
            default:              lim = TMR_W'(DIV_CYC);
        endcase
    end
    assign tmr_hit = (tmr_q == lim - 1'b1);

    // Next-state logic and completion decode
    always_comb begin
        state_d    = state_q;
        fin_err    = 1'b0;
        fin_ok     = 1'b0;
        fin_code   = E_NONE;
        do_restart = 1'b0;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_RST_LOW;
            S_RST_LOW: if (tmr_hit) begin
                if (ns_s) begin
                    state_d = S_IDLE; fin_err = 1'b1; fin_code = E_NORESP;
                end else state_d = S_WAIT_ST;
            end
            S_WAIT_ST: begin
                if (ns_s) state_d = S_SETTLE;
                else if (tmr_hit) begin
                    state_d = S_IDLE; fin_err = 1'b1; fin_code = E_TIMEOUT;
                end
            end
            S_SETTLE:  if (tmr_hit) state_d = (total_q == '0) ? S_TAIL : S_FETCH;
            S_FETCH:   if (byte_valid_i) state_d = S_BIT_LO;
            S_BIT_LO:  if (tmr_hit) begin
                if (!ns_s) begin
                    if (auto_q) state_d = S_RECOVER;
                    else begin
                        state_d = S_IDLE; fin_err = 1'b1; fin_code = E_CFG;
                    end
                end else state_d = S_BIT_HI;
            end
            S_BIT_HI:  if (tmr_hit) begin
                if (!sh_last) state_d = S_BIT_LO;
                else if (byte_cnt_q == total_q - 1'b1) state_d = S_TAIL;
                else state_d = S_FETCH;
            end
            S_TAIL:    if (tmr_hit) begin
                if (!ns_s) begin
                    state_d = S_IDLE; fin_err = 1'b1; fin_code = E_CFG;
                end else state_d = S_INIT_LO;
            end
            S_INIT_LO: if (tmr_hit) state_d = S_INIT_HI;
            S_INIT_HI: if (tmr_hit)
                state_d = (init_cnt_q == ICNT_W'(INIT_CLKS - 1)) ? S_FINAL : S_INIT_LO;
            S_FINAL: begin
                state_d = S_IDLE;
                if (cd_s) fin_ok = 1'b1;
                else begin fin_err = 1'b1; fin_code = E_NODONE; end
            end
            S_RECOVER: begin
                if (ns_s) begin state_d = S_SETTLE; do_restart = 1'b1; end
                else if (tmr_hit) begin
                    state_d = S_IDLE; fin_err = 1'b1; fin_code = E_TIMEOUT;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Timers, counters and held results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0; total_q <= '0; byte_cnt_q <= '0; init_cnt_q <= '0;
            auto_q <= 1'b0; hold_low_q <= 1'b0; ok_q <= 1'b0; err_q <= 1'b0;
            code_q <= E_NONE; restart_q <= 1'b0;
        end else begin
            tmr_q     <= (state_q != state_d) ? '0 : tmr_q + 1'b1;
            restart_q <= do_restart;
            if (state_q == S_IDLE && start_i) begin
                total_q <= total_bytes_i; auto_q <= auto_restart_i;
                hold_low_q <= 1'b0; ok_q <= 1'b0; err_q <= 1'b0; code_q <= E_NONE;
            end
            if (state_q == S_SETTLE) byte_cnt_q <= '0;
            else if (shift_now && sh_last) byte_cnt_q <= byte_cnt_q + 1'b1;
            if (state_q == S_TAIL) init_cnt_q <= '0;
            else if (state_q == S_INIT_HI && tmr_hit) init_cnt_q <= init_cnt_q + 1'b1;
            if (fin_ok) ok_q <= 1'b1;
            if (fin_err) begin
                err_q <= 1'b1; code_q <= fin_code;
                if (fin_code == E_NORESP) hold_low_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ncfg_o       = !((state_q == S_RST_LOW) || hold_low_q);
        dclk_o       = (state_q == S_BIT_HI) || (state_q == S_INIT_HI);
        data0_o      = ((state_q == S_BIT_LO) || (state_q == S_BIT_HI)) && sh_bit;
        byte_ready_o = (state_q == S_FETCH);
        busy_o       = (state_q != S_IDLE);
        restart_o    = restart_q;
        done_ok_o    = ok_q;
        err_o        = err_q;
        err_code_o   = code_q;
    end

    // Guards
    p_quiet_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_o |-> (!dclk_o && !data0_o));
    p_noresp_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == E_NORESP && !busy_o) |-> !ncfg_o);
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(data0_o));
    p_no_ready_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> !dclk_o);
    p_ok_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok_o && err_o));
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ncfg_o) |-> !$past(busy_o));
endmodule

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;
    localparam int DIV = 3, PULSE = 6, DELAY = 4, TMO = 40, INITN = 50;

    logic clk = 0, rst_n = 0;
    always #2 clk = ~clk;

    logic start = 0, auto_r = 0;
    logic [7:0] total = 0;
    logic [7:0] bdata;
    logic bvalid, bready, ncfg, dclk, data0, busy, restart, ok, err;
    logic [2:0] code;
    logic m_ns = 1, m_cd = 0;

    ps_cfg_master #(.DIV_CYC(DIV), .PULSE_CYC(PULSE), .DELAY_CYC(DELAY),
        .TIMEOUT_CYC(TMO), .INIT_CLKS(INITN), .LEN_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .auto_restart_i(auto_r),
        .total_bytes_i(total), .byte_data_i(bdata), .byte_valid_i(bvalid),
        .byte_ready_o(bready), .ncfg_o(ncfg), .dclk_o(dclk), .data0_o(data0),
        .nstatus_i(m_ns), .confdone_i(m_cd), .busy_o(busy), .restart_o(restart),
        .done_ok_o(ok), .err_o(err), .err_code_o(code));

    int checks = 0, fails = 0;
    task automatic check(input bit c, input string req, input int act, input int exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Byte source
    logic [7:0] mem [0:7];
    int src_n = 0, ptr = 0;
    logic src_clr = 0;
    assign bvalid = (ptr < src_n);
    assign bdata  = mem[ptr % 8];
    always @(posedge clk) begin
        if (src_clr || restart) ptr <= 0;
        else if (bvalid && bready) ptr <= ptr + 1;
    end

    // Device model
    bit m_noresp = 0, m_stuck = 0, m_nocd = 0;
    int m_err_at = -1, m_rec = 0, exp_bits = 0;
    int bits = 0, ecnt = 0, rel = 0;
    bit err_hold = 0, err_done = 0;
    logic dprev = 0;
    logic [7:0] cap [0:7];
    always @(posedge clk) begin
        dprev <= dclk;
        if (!ncfg) begin
            m_ns <= m_noresp; m_cd <= 0; bits <= 0; rel <= 0;
            err_hold <= 0; err_done <= 0;
        end else if (err_hold) begin
            ecnt <= ecnt + 1;
            if (m_rec > 0 && ecnt == m_rec) begin m_ns <= 1; err_hold <= 0; end
        end else if (!m_ns) begin
            if (!m_stuck) begin rel <= rel + 1; if (rel == 3) m_ns <= 1; end
        end else if (dclk && !dprev && !m_cd) begin
            cap[(bits/8)%8][bits%8] <= data0;
            bits <= bits + 1;
            if (!err_done && bits + 1 == m_err_at) begin
                m_ns <= 0; err_hold <= 1; err_done <= 1; ecnt <= 0; bits <= 0;
            end else if (bits + 1 == exp_bits && !m_nocd) m_cd <= 1;
        end
    end

    // Measurement
    logic meas_clr = 0;
    int cyc = 0, rises = 0, low_cnt = 0, falls = 0, hi_run = 0, hi_bad = 0;
    int ns_rise_cyc = -1, first_rise_cyc = -1, restarts = 0;
    logic mprev_d = 0, mprev_n = 1, mprev_s = 1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mprev_d <= dclk; mprev_n <= ncfg; mprev_s <= m_ns;
        if (meas_clr) begin
            rises <= 0; low_cnt <= 0; falls <= 0; hi_run <= 0; hi_bad <= 0;
            ns_rise_cyc <= -1; first_rise_cyc <= -1; restarts <= 0;
        end else begin
            if (dclk && !mprev_d) begin
                rises <= rises + 1;
                if (first_rise_cyc < 0) first_rise_cyc <= cyc;
            end
            if (dclk) hi_run <= hi_run + 1;
            else if (mprev_d) begin
                if (hi_run != DIV) hi_bad <= hi_bad + 1;
                hi_run <= 0;
            end
            if (!ncfg) low_cnt <= low_cnt + 1;
            if (!ncfg && mprev_n) falls <= falls + 1;
            if (m_ns && !mprev_s && ns_rise_cyc < 0) ns_rise_cyc <= cyc;
            if (restart) restarts <= restarts + 1;
        end
    end

    task automatic setup_model(input bit nr, input bit st, input bit ncd,
                               input int eat, input int rec);
        m_noresp = nr; m_stuck = st; m_nocd = ncd; m_err_at = eat; m_rec = rec;
    endtask

    task automatic run_load(input int n, input bit ar, input bit poke);
        for (int i = 0; i < 8; i++) mem[i] = 8'h5A ^ 8'(i * 37 + n);
        exp_bits = n * 8;
        @(negedge clk);
        total = 8'(n); auto_r = ar; start = 1; src_clr = 1; src_n = n; meas_clr = 1;
        @(negedge clk);
        start = 0; src_clr = 0; meas_clr = 0;
        if (poke) begin
            repeat (30) @(negedge clk);
            total = 8'd1; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_bytes(input int n, input string req);
        for (int i = 0; i < n; i++) check(cap[i] == mem[i], req, cap[i], mem[i]);
    endtask

    task automatic t_reset;
        check(ncfg == 1 && dclk == 0 && data0 == 0, "R1 pins", {ncfg, dclk, data0}, 3'b100);
        check(!busy && !bready && !ok && !err, "R1 status", {busy, bready, ok, err}, 0);
    endtask

    task automatic t_normal;
        setup_model(0, 0, 0, -1, 0);
        run_load(3, 0, 0);
        check(low_cnt == PULSE, "R2 pulse width", low_cnt, PULSE);
        check(first_rise_cyc - ns_rise_cyc >= DELAY, "R4 settle delay",
              first_rise_cyc - ns_rise_cyc, DELAY);
        check(hi_bad == 0, "R4 dclk high width", hi_bad, 0);
        check_bytes(3, "R5 lsb-first bytes");
        check(rises == 24 + INITN, "R7 init pulses", rises, 24 + INITN);
        check(ok && !err && code == 0, "R8 success", {ok, err, code}, 5'b10000);
    endtask

    task automatic t_noresp;
        setup_model(1, 0, 0, -1, 0);
        run_load(2, 0, 0);
        check(err && code == 1, "R3 code", code, 1);
        repeat (5) @(negedge clk);
        check(ncfg == 0, "R3 request held low", ncfg, 0);
        check(rises == 0, "R3 no clocks", rises, 0);
    endtask

    task automatic t_timeout;
        setup_model(0, 1, 0, -1, 0);
        run_load(2, 0, 0);
        check(err && code == 2, "R9 timeout code", code, 2);
        check(rises == 0 && ncfg == 1, "R9 no clocks", rises, 0);
    endtask

    task automatic t_cfg_err;
        setup_model(0, 0, 0, 10, 0);
        run_load(3, 0, 0);
        check(err && !ok && code == 3, "R6 cfg error code", code, 3);
        check(rises < 24, "R6 stopped early", rises, 24);
        begin
            int r0 = rises;
            repeat (20) @(negedge clk);
            check(rises == r0, "R6 no later clocks", rises, r0);
        end
    endtask

    task automatic t_nodone;
        setup_model(0, 0, 1, -1, 0);
        run_load(2, 0, 0);
        check(err && !ok && code == 4, "R8 no-done code", code, 4);
        check(rises == 16 + INITN, "R7 pulses with no done", rises, 16 + INITN);
    endtask

    task automatic t_restart;
        setup_model(0, 0, 0, 5, 12);
        run_load(3, 1, 0);
        check(restarts == 1, "R10 one restart pulse", restarts, 1);
        check(ok && !err, "R10 success after restart", {ok, err}, 2'b10);
        check(falls == 1, "R10 no new request pulse", falls, 1);
        check_bytes(3, "R10 bytes from byte 0");
    endtask

    task automatic t_busy_start;
        setup_model(0, 0, 0, -1, 0);
        run_load(4, 0, 1);
        check(falls == 1, "R11 single request pulse", falls, 1);
        check(ok && rises == 32 + INITN, "R11 full length kept", rises, 32 + INITN);
        check_bytes(4, "R11 bytes");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_noresp();
        t_timeout();
        t_cfg_err();
        t_nodone();
        t_restart();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule